// File: doc/BRIEF.md
# Keyed Nonvolatile Array Command Controller

This block is a byte-wide register peripheral through which a processor reads, programs and erases a small nonvolatile data array held inside the block as a register-file model. Software loads a target address, a data byte and an operation code, then releases the operation by writing a two-byte unlock key to a trigger register. The controller runs the operation for a set number of microseconds, which it derives from a clock-rate register, and holds a busy output high during that time. A read returns the stored byte in the data register. A program can only clear bits. An erase restores a whole 512-byte sector to 0xFF. A rejected or mis-keyed command raises a sticky fail flag.

The control register also carries an enable bit and a restart-source selector. It also has a self-clearing software-reset request that produces a one-cycle pulse on an output pin. The register port is a plain single-cycle write strobe with a combinational read-back. It has no valid/ready handshake: no data stream leaves the block, and a busy operation drops writes instead of back-pressuring them.

Top module: `eep_cmd_ctrl`

## Requirements
- R1: After reset every register reads 0x00, `busy` is 0 and `rst_req` is 0.
- R2: An operation starts only after a trigger-register (offset 5) write of 0x5A is followed, on the next trigger write, by 0xA5. Writes to other registers in between do not break the sequence.
- R3: Any trigger write that is not the expected key step sets the fail flag and clears the unlock state. A lone 0xA5 therefore never starts an operation.
- R4: Operation code 01 (read) loads the addressed array byte into the data register (offset 4) by the time `busy` falls.
- R5: Operation code 10 (program) replaces the addressed byte with the old byte AND the data register.
- R6: Operation code 11 (erase) sets all 512 bytes of the sector holding the address to 0xFF and leaves other sectors unchanged.
- R7: A keyed command is rejected if the enable bit is 0, if the operation code is 00, or if the address {ADDR_HI, ADDR_LO} is not below ARRAY_BYTES. A rejected command sets the fail flag, leaves `busy` low and leaves the array unchanged.
- R8: The fail flag (control bit 4) stays set until a control write with bit 4 = 0 clears it. Writing bit 4 = 1 never sets it.
- R9: `busy` rises in the cycle after the completing key write. It stays high for D × max(WAIT, 1) cycles, where D is 1 for a read, 6 for a program and 4000 for an erase, and WAIT is the clock-rate register (offset 6).
- R10: Register writes made while `busy` is high have no effect.
- R11: A control write with bit 5 = 1 pulses `rst_req` for exactly the next cycle. `rst_src` shows the restart-source bit 6 as written. Bit 5 always reads back 0.
- R12: Register map: 0 control (bit 7 enable, bit 6 restart source, bit 5 reset, bit 4 fail, others read 0); 1 operation code (low two bits kept); 2 address high; 3 address low; 4 data; 5 trigger (reads 0x00); 6 clock rate in MHz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset for write and read-back |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read-back of the register at `reg_addr` |
| busy | output | 1 | Operation in progress |
| rst_req | output | 1 | One-cycle software reset request |
| rst_src | output | 1 | Latched restart-source selection |

## Verification
Register writes take effect at the clock edge that samples the strobe. The fail flag, register contents and `rst_req` are therefore due one cycle after that write, and `busy` is already high in the cycle after the second key byte. The bench samples these at the falling edge directly after the write edge. It measures busy length by counting whole cycles until `busy` drops, so a duration that is off by one cycle shows as a count mismatch. Read and program results are checked only after `busy` has fallen, through a read-back of the data register or of a later read operation.

// File: rtl/eep_ctl_pkg.sv
package eep_ctl_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'b00,
    OP_READ  = 2'b01,
    OP_PROG  = 2'b10,
    OP_ERASE = 2'b11
  } eep_op_e;

  localparam logic [2:0] REG_CTRL = 3'd0;
  localparam logic [2:0] REG_CMD  = 3'd1;
  localparam logic [2:0] REG_AHI  = 3'd2;
  localparam logic [2:0] REG_ALO  = 3'd3;
  localparam logic [2:0] REG_DATA = 3'd4;
  localparam logic [2:0] REG_TRIG = 3'd5;
  localparam logic [2:0] REG_WAIT = 3'd6;

  localparam int CTL_EN   = 7;
  localparam int CTL_RSRC = 6;
  localparam int CTL_SRST = 5;
  localparam int CTL_FAIL = 4;

endpackage

// File: rtl/eep_key_unlock.sv
module eep_key_unlock #(
  parameter logic [7:0] KEY_A = 8'h5A,
  parameter logic [7:0] KEY_B = 8'hA5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trig_we,
  input  logic [7:0] trig_data,
  output logic       fire,
  output logic       bad
);

  logic armed_q;

  // second step completes the key; any other trigger write is a misstep
  always_comb begin
    fire = trig_we && armed_q && (trig_data == KEY_B);
    bad  = trig_we && (armed_q ? (trig_data != KEY_B) : (trig_data != KEY_A));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       armed_q <= 1'b0;
    else if (trig_we) armed_q <= !armed_q && (trig_data == KEY_A);
  end

  assert_key_rearm_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire || bad) |=> !armed_q);

  assert_key_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(fire && bad));

endmodule

// File: rtl/eep_us_timer.sv
module eep_us_timer #(
  parameter int US_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [US_W-1:0] dur_us,
  input  logic [7:0]      mhz,
  output logic            busy,
  output logic            done
);

  logic [7:0]      pre_q;
  logic [US_W-1:0] left_q;
  logic            busy_q;
  logic [7:0]      mhz_eff;
  logic            last_pre;

  always_comb begin
    mhz_eff  = (mhz == 8'd0) ? 8'd1 : mhz;
    last_pre = (pre_q == mhz_eff - 8'd1);
    done     = busy_q && last_pre && (left_q == US_W'(1));
    busy     = busy_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pre_q  <= '0;
      left_q <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      pre_q  <= '0;
      left_q <= dur_us;
    end else if (busy_q) begin
      if (last_pre) begin
        pre_q  <= '0;
        left_q <= left_q - US_W'(1);
        if (left_q == US_W'(1)) busy_q <= 1'b0;
      end else begin
        pre_q <= pre_q + 8'd1;
      end
    end
  end

  assert_busy_starts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy_q);

  assert_busy_ends_on_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(done));

endmodule

// File: rtl/eep_array.sv
module eep_array #(
  parameter int  BYTES  = 1024,
  parameter int  SECTOR = 512,
  localparam int AW     = $clog2(BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  input  logic          prog_en,
  input  logic [AW-1:0] prog_addr,
  input  logic [7:0]    prog_data,
  input  logic          erase_start,
  input  logic [AW-1:0] erase_addr,
  output logic          sweep_busy
);

  localparam int SW = $clog2(SECTOR);

  logic [7:0]    mem [BYTES];
  logic [7:0]    old_byte;
  logic          on_q;
  logic [SW-1:0] idx_q;
  logic [AW-1:0] sweep_addr;

  assign rd_data    = mem[rd_addr];
  assign old_byte   = mem[prog_addr];
  assign sweep_busy = on_q;

  generate
    if (BYTES > SECTOR) begin : g_multi
      logic [AW-SW-1:0] sec_q;
      always_ff @(posedge clk) begin
        if (!rst_n)           sec_q <= '0;
        else if (erase_start) sec_q <= erase_addr[AW-1:SW];
      end
      assign sweep_addr = {sec_q, idx_q};
    end else begin : g_single
      logic unused_erase;
      assign unused_erase = ^erase_addr;
      assign sweep_addr   = AW'(idx_q);
    end
  endgenerate

  // one byte of the sector is restored per cycle while the sweep runs
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      on_q  <= 1'b0;
      idx_q <= '0;
    end else if (erase_start) begin
      on_q  <= 1'b1;
      idx_q <= '0;
    end else if (on_q) begin
      if (idx_q == SW'(SECTOR - 1)) on_q <= 1'b0;
      idx_q <= idx_q + SW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (prog_en)   mem[prog_addr]  <= old_byte & prog_data;
    else if (on_q) mem[sweep_addr] <= 8'hFF;
  end

  assert_prog_clears_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    prog_en |=> mem[$past(prog_addr)] == ($past(old_byte) & $past(prog_data)));

  assert_sweep_writes_ff_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (on_q && !prog_en) |=> mem[$past(sweep_addr)] == 8'hFF);

endmodule

// File: rtl/eep_cmd_ctrl.sv
module eep_cmd_ctrl
  import eep_ctl_pkg::*;
#(
  parameter int         ARRAY_BYTES  = 1024,
  parameter int         SECTOR_BYTES = 512,
  parameter int         READ_US      = 1,
  parameter int         PROG_US      = 6,
  parameter int         ERASE_US     = 4000,
  parameter logic [7:0] KEY_A        = 8'h5A,
  parameter logic [7:0] KEY_B        = 8'hA5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       busy,
  output logic       rst_req,
  output logic       rst_src
);

  localparam int AW   = $clog2(ARRAY_BYTES);
  localparam int US_W = $clog2(ERASE_US + 1);

  logic       en_q, rsrc_q, fail_q, rst_req_q;
  eep_op_e    cmd_q;
  logic [7:0] ahi_q, alo_q, data_q, mhz_q;

  logic            wr_ok, trig_we, fire, bad;
  logic            in_range, launch_ok, fail_set;
  logic [15:0]     addr16;
  logic [AW-1:0]   arr_addr;
  logic [US_W-1:0] dur;
  logic            tmr_busy, tmr_done, sweep_busy;
  logic [7:0]      rd_byte;
  logic            prog_en, erase_start;

  always_comb begin
    wr_ok     = reg_we && !busy;
    trig_we   = wr_ok && (reg_addr == REG_TRIG);
    addr16    = {ahi_q, alo_q};
    arr_addr  = addr16[AW-1:0];
    in_range  = {1'b0, addr16} < 17'(ARRAY_BYTES);
    launch_ok = fire && en_q && (cmd_q != OP_IDLE) && in_range;
    fail_set  = bad || (fire && !launch_ok);
    case (cmd_q)
      OP_READ: dur = US_W'(READ_US);
      OP_PROG: dur = US_W'(PROG_US);
      default: dur = US_W'(ERASE_US);
    endcase
    prog_en     = tmr_done && (cmd_q == OP_PROG);
    erase_start = launch_ok && (cmd_q == OP_ERASE);
    busy        = tmr_busy || sweep_busy;
    rst_req     = rst_req_q;
    rst_src     = rsrc_q;
  end

  eep_key_unlock #(.KEY_A(KEY_A), .KEY_B(KEY_B)) u_key (
    .clk(clk), .rst_n(rst_n), .trig_we(trig_we), .trig_data(reg_wdata),
    .fire(fire), .bad(bad)
  );

  eep_us_timer #(.US_W(US_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(launch_ok), .dur_us(dur), .mhz(mhz_q),
    .busy(tmr_busy), .done(tmr_done)
  );

  eep_array #(.BYTES(ARRAY_BYTES), .SECTOR(SECTOR_BYTES)) u_array (
    .clk(clk), .rst_n(rst_n), .rd_addr(arr_addr), .rd_data(rd_byte),
    .prog_en(prog_en), .prog_addr(arr_addr), .prog_data(data_q),
    .erase_start(erase_start), .erase_addr(arr_addr), .sweep_busy(sweep_busy)
  );

  // software-visible registers; everything is frozen while busy
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      rsrc_q    <= 1'b0;
      fail_q    <= 1'b0;
      rst_req_q <= 1'b0;
      cmd_q     <= OP_IDLE;
      ahi_q     <= '0;
      alo_q     <= '0;
      data_q    <= '0;
      mhz_q     <= '0;
    end else begin
      rst_req_q <= wr_ok && (reg_addr == REG_CTRL) && reg_wdata[CTL_SRST];
      if (fail_set) fail_q <= 1'b1;
      else if (wr_ok && (reg_addr == REG_CTRL) && !reg_wdata[CTL_FAIL]) fail_q <= 1'b0;
      if (tmr_done && (cmd_q == OP_READ)) data_q <= rd_byte;
      if (wr_ok) begin
        case (reg_addr)
          REG_CTRL: begin
            en_q   <= reg_wdata[CTL_EN];
            rsrc_q <= reg_wdata[CTL_RSRC];
          end
          REG_CMD:  cmd_q  <= eep_op_e'(reg_wdata[1:0]);
          REG_AHI:  ahi_q  <= reg_wdata;
          REG_ALO:  alo_q  <= reg_wdata;
          REG_DATA: data_q <= reg_wdata;
          REG_WAIT: mhz_q  <= reg_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_addr)
      REG_CTRL: reg_rdata = {en_q, rsrc_q, 1'b0, fail_q, 4'b0};
      REG_CMD:  reg_rdata = {6'b0, cmd_q};
      REG_AHI:  reg_rdata = ahi_q;
      REG_ALO:  reg_rdata = alo_q;
      REG_DATA: reg_rdata = data_q;
      REG_WAIT: reg_rdata = mhz_q;
      default:  reg_rdata = 8'h00;
    endcase
  end

  assert_start_needs_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmr_busy) |-> $past(reg_we && reg_addr == REG_TRIG && reg_wdata == KEY_B));

  assert_reject_stays_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_set && !busy) |=> !busy);

  assert_fail_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_q && !(wr_ok && reg_addr == REG_CTRL && !reg_wdata[CTL_FAIL])) |=> fail_q);

  assert_frozen_when_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(ahi_q) && $stable(alo_q) && $stable(cmd_q) && $stable(mhz_q) &&
              $stable(en_q) && $stable(rsrc_q)));

  assert_reset_pulse_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(reg_we && !busy && reg_addr == REG_CTRL && reg_wdata[CTL_SRST]));

  assert_sweep_inside_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_busy |-> tmr_busy);

endmodule

// File: tb/eep_cmd_ctrl_bench.sv
module eep_cmd_ctrl_bench;

  localparam int LIMIT = 150000;
  localparam int SEL_REG = 0, SEL_BUSY = 1, SEL_RSTQ = 2, SEL_RSRC = 3, SEL_VAL = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       busy, rst_req, rst_src;

  eep_cmd_ctrl u_eep_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
    .rst_req(rst_req), .rst_src(rst_src)
  );

  always #4 clk = ~clk;

  typedef struct {
    int    sel;
    int    act;
    int    exp;
    string tag;
  } item_t;

  item_t q[$];
  item_t cur;
  int    checks = 0, errors = 0, cyc = 0, actv = 0;
  logic  fin = 1'b0;

  // monitor: sole owner of the counters, pops one expectation per falling edge
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (q.size() > 0) begin
      cur = q.pop_front();
      case (cur.sel)
        SEL_REG:  actv = int'(reg_rdata);
        SEL_BUSY: actv = int'(busy);
        SEL_RSTQ: actv = int'(rst_req);
        SEL_RSRC: actv = int'(rst_src);
        default:  actv = cur.act;
      endcase
      checks = checks + 1;
      if (actv != cur.exp) begin
        errors = errors + 1;
        $display("FAIL %s: actual %0h expected %0h", cur.tag, actv, cur.exp);
      end
    end
    if (cyc >= LIMIT) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, LIMIT);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end else if (fin && q.size() == 0) begin
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic expect_item(input int sel, input int act, input int exp, input string tag);
    q.push_back('{sel, act, exp, tag});
    @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk);
    #1;
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    #1;
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string tag);
    @(posedge clk);
    #1;
    reg_addr = a;
    expect_item(SEL_REG, 0, int'(e), tag);
  endtask

  task automatic wait_busy(output int n);
    n = 0;
    while (busy) begin
      @(posedge clk);
      #1;
      n = n + 1;
    end
  endtask

  task automatic run_op(input logic [1:0] op, input logic [15:0] a, input logic [7:0] d,
                        output int n);
    wr(3'd2, a[15:8]);
    wr(3'd3, a[7:0]);
    wr(3'd4, d);
    wr(3'd1, {6'b0, op});
    wr(3'd5, 8'h5A);
    wr(3'd5, 8'hA5);
    wait_busy(n);
  endtask

  task automatic read_byte(input logic [15:0] a, input logic [7:0] e, input string tag);
    int n;
    run_op(2'b01, a, 8'h00, n);
    rd(3'd4, e, tag);
  endtask

  initial begin
    int n;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    for (int i = 0; i < 7; i++) rd(3'(i), 8'h00, "R1 register reset value");
    expect_item(SEL_BUSY, 0, 0, "R1 busy after reset");
    expect_item(SEL_RSTQ, 0, 0, "R1 rst_req after reset");

    // R6/R9 erase both sectors with clock-rate 0 treated as 1
    wr(3'd0, 8'h80);
    run_op(2'b11, 16'h0010, 8'h00, n);
    expect_item(SEL_VAL, n, 4000, "R9 erase busy cycles");
    run_op(2'b11, 16'h0200, 8'h00, n);
    read_byte(16'h0000, 8'hFF, "R6 erased first byte");
    read_byte(16'h01FF, 8'hFF, "R6 erased last byte of sector");

    // R5/R9/R4 program and read at 2 MHz
    wr(3'd6, 8'd2);
    run_op(2'b10, 16'h0005, 8'h3C, n);
    expect_item(SEL_VAL, n, 12, "R9 program busy cycles");
    run_op(2'b01, 16'h0005, 8'h00, n);
    expect_item(SEL_VAL, n, 2, "R9 read busy cycles");
    rd(3'd4, 8'h3C, "R4 read returns programmed byte");
    run_op(2'b10, 16'h0005, 8'hF0, n);
    read_byte(16'h0005, 8'h30, "R5 program ANDs with old byte");

    // R6 erase touches only its own sector
    run_op(2'b10, 16'h0200, 8'h00, n);
    wr(3'd6, 8'd1);
    run_op(2'b11, 16'h01F0, 8'h00, n);
    read_byte(16'h0005, 8'hFF, "R6 sector restored to FF");
    read_byte(16'h0200, 8'h00, "R6 other sector untouched");

    // R2 key survives an unrelated write in between
    wr(3'd2, 8'h00); wr(3'd3, 8'h05); wr(3'd4, 8'h0F); wr(3'd1, 8'h02);
    wr(3'd5, 8'h5A);
    wr(3'd3, 8'h06);
    wr(3'd5, 8'hA5);
    expect_item(SEL_BUSY, 0, 1, "R2 busy right after completed key");
    wait_busy(n);
    read_byte(16'h0006, 8'h0F, "R2 interleaved key programs new address");

    // R3 wrong second key, then a lone second key
    wr(3'd5, 8'h5A);
    wr(3'd5, 8'h00);
    expect_item(SEL_BUSY, 0, 0, "R3 wrong key starts nothing");
    rd(3'd0, 8'h90, "R3 wrong key sets fail");
    wr(3'd0, 8'h80);
    rd(3'd0, 8'h80, "R8 fail cleared by writing bit4=0");
    wr(3'd5, 8'hA5);
    expect_item(SEL_BUSY, 0, 0, "R3 lone A5 starts nothing");
    wr(3'd3, 8'h44);
    rd(3'd0, 8'h90, "R8 fail stays set across other writes");
    wr(3'd0, 8'h80);
    wr(3'd0, 8'h90);
    rd(3'd0, 8'h80, "R8 writing bit4=1 does not set fail");

    // R7 rejected commands
    run_op(2'b00, 16'h0006, 8'h00, n);
    expect_item(SEL_VAL, n, 0, "R7 idle opcode no busy");
    rd(3'd0, 8'h90, "R7 idle opcode sets fail");
    wr(3'd0, 8'h80);
    run_op(2'b10, 16'h0400, 8'h00, n);
    expect_item(SEL_VAL, n, 0, "R7 out-of-range no busy");
    rd(3'd0, 8'h90, "R7 out-of-range sets fail");
    wr(3'd0, 8'h00);
    run_op(2'b10, 16'h0006, 8'h00, n);
    expect_item(SEL_VAL, n, 0, "R7 disabled no busy");
    rd(3'd0, 8'h10, "R7 disabled sets fail");
    wr(3'd0, 8'h80);
    read_byte(16'h0006, 8'h0F, "R7 array unchanged after rejects");

    // R10 writes during busy are dropped
    wr(3'd6, 8'd2);
    wr(3'd2, 8'h00); wr(3'd3, 8'h07); wr(3'd4, 8'h55); wr(3'd1, 8'h02);
    wr(3'd5, 8'h5A); wr(3'd5, 8'hA5);
    wr(3'd3, 8'h77);
    wr(3'd1, 8'h00);
    wait_busy(n);
    rd(3'd3, 8'h07, "R10 address low kept during busy");
    rd(3'd1, 8'h02, "R10 opcode kept during busy");
    read_byte(16'h0007, 8'h55, "R10 program used original address");

    // R11 software reset pulse
    wr(3'd0, 8'hE0);
    expect_item(SEL_RSTQ, 0, 1, "R11 rst_req pulse");
    expect_item(SEL_RSRC, 0, 1, "R11 restart source");
    expect_item(SEL_RSTQ, 0, 0, "R11 rst_req single cycle");
    rd(3'd0, 8'hC0, "R11 reset bit reads 0");

    // R12 register map
    wr(3'd2, 8'h12);
    rd(3'd2, 8'h12, "R12 address high");
    wr(3'd1, 8'hFE);
    rd(3'd1, 8'h02, "R12 opcode keeps low bits");
    rd(3'd5, 8'h00, "R12 trigger reads zero");
    wr(3'd6, 8'h07);
    rd(3'd6, 8'h07, "R12 clock rate");

    fin = 1'b1;
  end

endmodule